// File: doc/BRIEF.md
# Rotating Priority Arbiter

This block shares one resource among a small group of requesters so that no requester is starved. Each cycle it looks at the active-high request lines and grants at most one of them. The search for a winner starts at the requester just after the most recent grantee and wraps around. The grant is combinational from the requests in the same cycle, so a client sees its grant before the clock edge that ends its turn.

Internally the request vector is rotated so that the requester after the last grantee lands in slot 0. A plain fixed-priority resolver then picks the lowest-numbered active slot. A second rotator turns that one-hot pick back into the original requester positions. A small pointer register stores the binary ID of the last grantee. It loads only in cycles where some grant is issued. With no grant it keeps its value, so the priority order is unchanged.

Top module: `rr_prio_arbiter`

## Requirements
- R1: The grant vector `gnt` has at most one bit set in every cycle.
- R2: A grant bit is set only for a requester whose `req` bit is set in the same cycle.
- R3: Whenever at least one `req` bit is set, exactly one `gnt` bit is set in the same cycle, with no clock edge in between.
- R4: While `rst_n` is low, `last_id` is preset to all ones (3 for four requesters), so requester 0 has the highest priority in the first arbitration after reset.
- R5: With pointer value p, the grant goes to the first requesting index in the circular order p+1, p+2, …, p+N (taken modulo N).
- R6: On a rising clock edge with a grant on line k, `last_id` becomes k in plain binary (line 0 → 0, line 1 → 1, line 2 → 2, line 3 → 3).
- R7: On a rising clock edge with no request (and therefore no grant), `last_id` keeps its value.
- R8: With all requesters continuously active, the grants visit lines 0, 1, 2, 3, 0, … on successive cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pointer updates on the rising edge |
| rst_n | input | 1 | Active-low reset; presets the pointer to all ones |
| req | input | N_REQ (4) | Active-high request lines, bit k from requester k |
| gnt | output | N_REQ (4) | One-hot (or zero) grant lines, same-cycle combinational |
| last_id | output | ID_W (2) | Binary ID of the most recent grantee |

## Verification
The bench tests every pointer value against all sixteen request patterns. It first parks the pointer with a single-requester cycle, then applies the pattern. This covers the wrap-around cases, where the winner lies below the pointer. A rotator with an off-by-one amount, or one turning the wrong way, would grant a requester one slot away or mirrored. The bench also applies empty-request cycles between active ones. A pointer that loaded a zero encoding there would fall back to requester 0 and break the fairness order. Finally it checks the preset value, because a pointer that cleared to zero would start the rotation at requester 1 instead of 0.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
   // rotator implementation variants
   localparam int ROT_LOG_STAGES = 0;
   localparam int ROT_DIRECT_MUX = 1;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/rra_rotator.sv
module rra_rotator
   import rr_arb_pkg::*;
#(
   parameter int N_REQ    = 4,
   parameter bit TO_LEFT  = 1'b0,
   parameter int IMPL     = ROT_LOG_STAGES,
   localparam int ID_W    = $clog2(N_REQ)
) (
   input  logic [N_REQ-1:0] din,
   input  logic [ID_W-1:0]  amt,
   output logic [N_REQ-1:0] dout
);
   generate
      if (!is_pow2(N_REQ)) begin : g_bad_n
         $error("rra_rotator: N_REQ must be a power of two >= 2");
      end
      if (IMPL != ROT_LOG_STAGES && IMPL != ROT_DIRECT_MUX) begin : g_bad_impl
         $error("rra_rotator: unknown IMPL");
      end

      if (IMPL == ROT_LOG_STAGES) begin : g_log
         logic [ID_W:0][N_REQ-1:0] stg;
         assign stg[0] = din;
         for (genvar s = 0; s < ID_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            for (genvar i = 0; i < N_REQ; i++) begin : g_bit
               localparam int SRC = TO_LEFT ? ((i - STEP + N_REQ) % N_REQ)
                                            : ((i + STEP) % N_REQ);
               assign stg[s+1][i] = amt[s] ? stg[s][SRC] : stg[s][i];
            end
         end
         assign dout = stg[ID_W];
      end else begin : g_mux
         always_comb begin
            for (int i = 0; i < N_REQ; i++) begin
               logic [ID_W-1:0] src;
               if (TO_LEFT) src = ID_W'(i) - amt;
               else         src = ID_W'(i) + amt;
               dout[i] = din[src];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rra_fixed_prio.sv
module rra_fixed_prio #(
   parameter int N_REQ = 4
) (
   input  logic [N_REQ-1:0] r,
   output logic [N_REQ-1:0] g
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      g     = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (r[i] && !taken) begin
            g[i]  = 1'b1;
            taken = 1'b1;
         end
      end
   end

   always_comb begin
      AST_FP_AT_MOST_ONE: assert (!$isunknown(r) -> $onehot0(g)); // R1
   end
endmodule

// File: rtl/rra_ptr_reg.sv
module rra_ptr_reg #(
   parameter int N_REQ = 4,
   localparam int ID_W = $clog2(N_REQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] gnt,
   output logic [ID_W-1:0]  id_q
);
   logic [ID_W-1:0] id_enc;
   logic            any_gnt;

   // each ID bit is the OR of the grant lines whose index has that bit set
   generate
      for (genvar b = 0; b < ID_W; b++) begin : g_enc
         logic [N_REQ-1:0] sel;
         for (genvar i = 0; i < N_REQ; i++) begin : g_sel
            assign sel[i] = ((i >> b) & 1) != 0;
         end
         assign id_enc[b] = |(gnt & sel);
      end
   endgenerate

   assign any_gnt = |gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       id_q <= '1;
      else if (any_gnt) id_q <= id_enc;
   end

   AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !any_gnt |=> $stable(id_q)); // R7
   AST_ID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      any_gnt |=> $past(gnt) == (N_REQ'(1) << id_q)); // R6
endmodule

// File: rtl/rr_prio_arbiter.sv
module rr_prio_arbiter
   import rr_arb_pkg::*;
#(
   parameter int N_REQ    = 4,
   parameter int ROT_IMPL = ROT_LOG_STAGES,
   localparam int ID_W    = $clog2(N_REQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   output logic [N_REQ-1:0] gnt,
   output logic [ID_W-1:0]  last_id
);
   generate
      if (!is_pow2(N_REQ)) begin : g_bad_n
         $error("rr_prio_arbiter: N_REQ must be a power of two >= 2");
      end
   endgenerate

   logic [ID_W-1:0]  rot_amt;
   logic [N_REQ-1:0] req_rot;
   logic [N_REQ-1:0] gnt_rot;

   // rotate by pointer+1 so the requester after the last grantee sits in slot 0
   assign rot_amt = last_id + ID_W'(1);

   rra_rotator #(.N_REQ(N_REQ), .TO_LEFT(1'b0), .IMPL(ROT_IMPL)) i_rot_in (
      .din (req),
      .amt (rot_amt),
      .dout(req_rot)
   );

   rra_fixed_prio #(.N_REQ(N_REQ)) i_prio (
      .r(req_rot),
      .g(gnt_rot)
   );

   rra_rotator #(.N_REQ(N_REQ), .TO_LEFT(1'b1), .IMPL(ROT_IMPL)) i_rot_out (
      .din (gnt_rot),
      .amt (rot_amt),
      .dout(gnt)
   );

   rra_ptr_reg #(.N_REQ(N_REQ)) i_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .gnt  (gnt),
      .id_q (last_id)
   );

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R1
   AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0); // R2
   AST_GNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt)); // R3
   AST_RST_PRESET: assert property (@(posedge clk)
      !rst_n |=> (last_id == '1)); // R4
endmodule

// File: tb/test_rr_prio_arbiter.sv
module test_rr_prio_arbiter;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] gnt;
   logic [1:0]   last_id;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk; // 50 MHz

   rr_prio_arbiter #(.N_REQ(N)) i_rr_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .last_id(last_id)
   );

   function automatic logic [N-1:0] exp_gnt(input int p, input logic [N-1:0] r);
      for (int j = 1; j <= N; j++) begin
         int k;
         k = (p + j) % N;
         if (r[k]) return N'(1) << k;
      end
      return '0;
   endfunction

   task automatic chk_g(input string tag, input logic [N-1:0] exp);
      n_chk++;
      if (gnt !== exp) begin
         n_bad++;
         $display("FAIL %s gnt=%b expected %b (req=%b id=%0d)", tag, gnt, exp, req, last_id);
      end
   endtask

   task automatic chk_id(input string tag, input int exp);
      n_chk++;
      if (last_id !== 2'(exp)) begin
         n_bad++;
         $display("FAIL %s last_id=%0d expected %0d", tag, last_id, exp);
      end
   endtask

   // drive at negedge, check combinational grant, then pointer after the edge
   task automatic apply(input logic [N-1:0] r, input int p, input string tag, output int p_next);
      @(negedge clk);
      req = r;
      #2;
      chk_g(tag, exp_gnt(p, r));
      p_next = (r == '0) ? p : $clog2(exp_gnt(p, r));
      @(posedge clk);
      #1;
      chk_id(tag, p_next);
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int p;
      @(posedge clk);
      #1;
      chk_id("R4 preset", 3);
      @(negedge clk);
      rst_n = 1'b1;
      p = 3;

      // R4: first arbitration favours requester 0
      apply(4'b1111, p, "R4 first", p);

      // R8: continuous full load rotates 1,2,3,0,1...
      for (int c = 0; c < 7; c++) begin
         int q;
         apply(4'b1111, p, "R8 cycle", q);
         p = q;
      end

      // R3 R5 R6: every pointer value against every pattern
      for (int k = 0; k < N; k++) begin
         for (int v = 0; v < 16; v++) begin
            int q;
            apply(N'(1) << k, p, "R6 park", q);
            p = q;
            apply(N'(v), p, "R5 sweep", q);
            p = q;
         end
      end

      // R7: idle cycles leave pointer and order intact
      for (int k = 0; k < N; k++) begin
         int q;
         apply(N'(1) << k, p, "R6 park", q);
         p = q;
         apply('0, p, "R7 idle", q);
         p = q;
         apply('0, p, "R7 idle", q);
         p = q;
         apply(4'b1111, p, "R7 after idle", q);
         p = q;
      end

      // R4: reset mid-run restores the preset
      @(negedge clk);
      rst_n = 1'b0;
      req = '0;
      @(posedge clk);
      #1;
      chk_id("R4 reset again", 3);
      @(negedge clk);
      rst_n = 1'b1;
      p = 3;
      apply(4'b1010, p, "R5 after reset", p);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule